// File: doc/BRIEF.md
# Write-Through Second-Level Cache Controller

This block sits between a first-level cache and main memory and serves whole-block requests. It is 8-way set associative. Reads that hit answer from the stored line. A read that misses fetches the block from memory and installs it. Invalid ways are filled first, and after that a tree pseudo-LRU picks the victim.

Writes follow a write-through, no-allocate policy. Every accepted write goes into a small write queue that drains to memory in order. A write that hits also updates the stored line. A write that misses leaves the cache contents untouched. The upper requester gets its acknowledge as soon as the queue has taken the write, without waiting for memory. A read miss never overtakes a queued write to the same block: it holds until that entry has reached memory. Lines are never dirty, so an eviction never produces a memory write.

Both sides use a request/acknowledge handshake. The requester raises valid and holds address, direction (write = 1) and write data stable. The receiver answers with a one-cycle ready pulse. The requester then drops valid.

Top module: `l2wt_cache`

## Requirements
- R1: In the first cycle after reset is released, `up_ready` and `mem_valid` are both low.
- R2: A read hit raises `up_ready` one cycle after the request is sampled. It returns the stored block and causes no memory access.
- R3: A read miss with an empty queue and an idle memory port issues exactly one memory read of that block. It returns the memory data and installs the block. `up_ready` appears `mem_latency + 2` cycles after the request is driven.
- R4: A write that hits updates the stored line, so a later read of that block hits and returns the written data.
- R5: A write is acknowledged one cycle after it is sampled whenever the queue has space, independent of memory latency.
- R6: A write that misses installs nothing: a later read of that block is a miss and fetches it from memory.
- R7: Every acknowledged write reaches memory exactly once, with its address and data, in acknowledgement order.
- R8: While the write queue is full, a write is not acknowledged.
- R9: A read miss to a block with a queued write issues its memory read only after that write has completed at memory.
- R10: A fill uses the lowest-numbered invalid way. With all eight ways valid, it evicts the tree pseudo-LRU victim, which after eight sequential fills is the first-filled block.
- R11: Evictions cause no memory writes. Only one of drain and fill drives the memory port at a time. While `mem_valid` is high without `mem_ready`, address, direction and data stay stable.
- R12: `up_ready` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Request from the first-level cache |
| up_rw | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Block address; the low log2(SETS) bits select the set |
| up_wdata | input | DATA_W | Block write data |
| up_rdata | output | DATA_W | Block read data, valid with `up_ready` |
| up_ready | output | 1 | One-cycle acknowledge to the requester |
| mem_valid | output | 1 | Request to memory |
| mem_rw | output | 1 | 1 = write (queue drain), 0 = read (fill) |
| mem_addr | output | ADDR_W | Block address to memory |
| mem_wdata | output | DATA_W | Block data for a drain write |
| mem_rdata | input | DATA_W | Block data from memory, valid with `mem_ready` |
| mem_ready | input | 1 | One-cycle acknowledge from memory |

## Verification
Hits and writes with queue space are due in exactly one cycle. An idle read miss is due `mem_latency + 2` cycles after the request is driven. A write facing a full queue, and a read miss behind a matching queued write, must take longer than those figures. The bench counts falling edges from the moment it drives a request until it sees `up_ready`, and compares that count against these figures. The memory model counts cycles the same way before it answers. Each memory access is checked in the cycle it completes: a write against the oldest entry of the bench's own queue of acknowledged writes, and a read against that queue, which must hold no entry for the block being read.

// File: rtl/l2wt_pkg.sv
package l2wt_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MISS,
        S_FILL,
        S_RESP
    } l2_state_e;

    localparam int unsigned TREE_MAX = 63;

    // Mark the path to 'way' as recently used: each node on the path points away.
    function automatic logic [TREE_MAX-1:0] plru_touch(input logic [TREE_MAX-1:0] tree,
                                                       input int unsigned way,
                                                       input int unsigned levels);
        logic [TREE_MAX-1:0] t;
        int unsigned node;
        logic b;
        t = tree;
        node = 0;
        for (int l = 5; l >= 0; l--) begin
            if (l < int'(levels)) begin
                b = 1'((way >> l) & 32'd1);
                t[node] = ~b;
                node = 2 * node + 1 + 32'(b);
            end
        end
        return t;
    endfunction

    // Follow the node pointers down to the way to replace next.
    function automatic int unsigned plru_victim(input logic [TREE_MAX-1:0] tree,
                                                input int unsigned levels);
        int unsigned node;
        int unsigned v;
        logic b;
        node = 0;
        v = 0;
        for (int l = 5; l >= 0; l--) begin
            if (l < int'(levels)) begin
                b = tree[node];
                v = (v << 1) | 32'(b);
                node = 2 * node + 1 + 32'(b);
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/l2wt_wbuf.sv
module l2wt_wbuf #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              q_hit
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_entry_t;

    wb_entry_t        ent_q [DEPTH];
    logic [DEPTH-1:0] occ_q;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEPTH-1:0] hit_vec;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign head_addr = ent_q[rd_ptr_q].addr;
    assign head_data = ent_q[rd_ptr_q].data;

    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        assign hit_vec[i] = occ_q[i] && (ent_q[i].addr == q_addr);
    end
    assign q_hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            if (push && !full) begin
                ent_q[wr_ptr_q] <= '{addr: push_addr, data: push_data};
                occ_q[wr_ptr_q] <= 1'b1;
                wr_ptr_q        <= step(wr_ptr_q);
            end
            if (pop && !empty) begin
                occ_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q        <= step(rd_ptr_q);
            end
            if ((push && !full) && !(pop && !empty)) cnt_q <= cnt_q + 1'b1;
            else if (!(push && !full) && (pop && !empty)) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/l2wt_lookup.sv
module l2wt_lookup
    import l2wt_pkg::*;
#(
    parameter int unsigned TAG_W = 14,
    parameter int unsigned WAYS  = 8,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       way_vld,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic [WAYS-2:0]       tree,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [WAY_W-1:0]      victim
);
    logic [WAYS-1:0]  hit_vec;
    logic             inv_found;
    logic [WAY_W-1:0] inv_way;
    logic [TREE_MAX-1:0] wide_tree;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_vld[w] && (way_tags[w*TAG_W +: TAG_W] == req_tag);
    end
    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
        end
    end

    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_vld[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

    always_comb begin
        wide_tree = '0;
        wide_tree[WAYS-2:0] = tree;
    end

    assign victim = inv_found ? inv_way : WAY_W'(plru_victim(wide_tree, WAY_W));
endmodule

// File: rtl/l2wt_cache.sv
module l2wt_cache
    import l2wt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SETS     = 4,
    parameter int unsigned WAYS     = 8,
    parameter int unsigned WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic              up_rw,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_ready,
    output logic              mem_valid,
    output logic              mem_rw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;
    localparam int unsigned WAY_W = $clog2(WAYS);

    l2_state_e         state_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] rdata_q;
    logic              drain_busy_q;

    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS];
    logic [WAYS-1:0]   vld_q  [SETS];
    logic [WAYS-2:0]   tree_q [SETS];

    logic [ADDR_W-1:0]     cur_addr;
    logic [IDX_W-1:0]      cur_idx;
    logic [TAG_W-1:0]      cur_tag;
    logic [WAYS*TAG_W-1:0] set_tags;
    logic                  lk_hit;
    logic [WAY_W-1:0]      lk_way, lk_victim;

    logic              wb_push, wb_pop, wb_empty, wb_full, wb_match;
    logic [ADDR_W-1:0] wb_head_addr;
    logic [DATA_W-1:0] wb_head_data;

    logic idle_now, fill_active, fill_claim, wr_acc, rd_acc;

    function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] t, input logic [WAY_W-1:0] w);
        logic [TREE_MAX-1:0] wide;
        wide = '0;
        wide[WAYS-2:0] = t;
        wide = plru_touch(wide, 32'(w), WAY_W);
        return wide[WAYS-2:0];
    endfunction

    assign idle_now    = (state_q == S_IDLE);
    assign fill_active = (state_q == S_FILL);
    assign cur_addr    = idle_now ? up_addr : req_addr_q;
    assign cur_idx     = cur_addr[IDX_W-1:0];
    assign cur_tag     = cur_addr[ADDR_W-1:IDX_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tag_q[cur_idx][w];
    end

    l2wt_lookup #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lookup (
        .way_vld (vld_q[cur_idx]),
        .way_tags(set_tags),
        .req_tag (cur_tag),
        .tree    (tree_q[cur_idx]),
        .hit     (lk_hit),
        .hit_way (lk_way),
        .victim  (lk_victim)
    );

    assign wr_acc  = idle_now && up_valid && up_rw && !wb_full;
    assign rd_acc  = idle_now && up_valid && !up_rw;
    assign wb_push = wr_acc;
    assign wb_pop  = drain_busy_q && mem_ready;

    l2wt_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .push     (wb_push),
        .push_addr(up_addr),
        .push_data(up_wdata),
        .pop      (wb_pop),
        .head_addr(wb_head_addr),
        .head_data(wb_head_data),
        .empty    (wb_empty),
        .full     (wb_full),
        .q_addr   (cur_addr),
        .q_hit    (wb_match)
    );

    // A pending fill keeps new drains off the port once no matching write remains.
    assign fill_claim = ((state_q == S_MISS) && !wb_match) || fill_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            drain_busy_q <= 1'b0;
        end else if (wb_pop) begin
            drain_busy_q <= 1'b0;
        end else if (!drain_busy_q && !wb_empty && !fill_claim) begin
            drain_busy_q <= 1'b1;
        end
    end

    assign mem_valid = drain_busy_q || fill_active;
    assign mem_rw    = drain_busy_q;
    assign mem_addr  = drain_busy_q ? wb_head_addr : req_addr_q;
    assign mem_wdata = drain_busy_q ? wb_head_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            req_addr_q <= '0;
            rdata_q    <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                tree_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    data_q[s][w] <= '0;
                end
            end
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (wr_acc) begin
                        if (lk_hit) begin
                            data_q[cur_idx][lk_way] <= up_wdata;
                            tree_q[cur_idx]         <= touch(tree_q[cur_idx], lk_way);
                        end
                        state_q <= S_RESP;
                    end else if (rd_acc) begin
                        req_addr_q <= up_addr;
                        if (lk_hit) begin
                            rdata_q         <= data_q[cur_idx][lk_way];
                            tree_q[cur_idx] <= touch(tree_q[cur_idx], lk_way);
                            state_q         <= S_RESP;
                        end else begin
                            state_q <= S_MISS;
                        end
                    end
                end
                S_MISS: begin
                    if (!wb_match && !drain_busy_q) state_q <= S_FILL;
                end
                S_FILL: begin
                    if (mem_ready) begin
                        tag_q[cur_idx][lk_victim]  <= cur_tag;
                        data_q[cur_idx][lk_victim] <= mem_rdata;
                        vld_q[cur_idx][lk_victim]  <= 1'b1;
                        tree_q[cur_idx]            <= touch(tree_q[cur_idx], lk_victim);
                        rdata_q                    <= mem_rdata;
                        state_q                    <= S_RESP;
                    end
                end
                S_RESP: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign up_ready = (state_q == S_RESP);
    assign up_rdata = rdata_q;
endmodule

// File: rtl/l2wt_cache_chk.sv
module l2wt_cache_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_rw,
    input logic              up_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_rw,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              wb_full,
    input logic              wb_match,
    input logic              drain_busy_q,
    input logic              fill_active,
    input logic              idle_now,
    input logic              lk_hit
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!up_ready && !mem_valid));

    // R2
    read_hit_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_now && up_valid && !up_rw && lk_hit) |=> up_ready);

    // R5
    write_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_now && up_valid && up_rw && !wb_full) |=> up_ready);

    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_now && up_valid && up_rw && wb_full) |=> !up_ready);

    // R9
    no_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        fill_active |-> !wb_match);

    // R11
    port_owner_chk: assert property (@(posedge clk) disable iff (rst)
        !(drain_busy_q && fill_active));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_rw) && $stable(mem_wdata)));

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        up_ready |=> !up_ready);
endmodule

bind l2wt_cache l2wt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .up_valid    (up_valid),
    .up_rw       (up_rw),
    .up_ready    (up_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_rw      (mem_rw),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .wb_full     (wb_full),
    .wb_match    (wb_match),
    .drain_busy_q(drain_busy_q),
    .fill_active (fill_active),
    .idle_now    (idle_now),
    .lk_hit      (lk_hit)
);

// File: tb/l2wt_cache_bench.sv
`timescale 1ns/1ps
module l2wt_cache_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_valid = 1'b0, up_rw = 1'b0;
    logic [15:0] up_addr = '0;
    logic [31:0] up_wdata = '0, up_rdata;
    logic        up_ready;
    logic        mem_valid, mem_rw;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2 clk = ~clk;

    l2wt_cache u_l2wt_cache (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_rw(up_rw), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_rdata(up_rdata), .up_ready(up_ready),
        .mem_valid(mem_valid), .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    typedef struct { int a; logic [31:0] d; } wr_t;

    int n_chk = 0, n_err = 0;
    int lat = 3;
    int mem_rd_cnt = 0, mem_wr_cnt = 0, n_wr = 0, ev_idx = 0;
    int last_wr_ev [int];
    int last_rd_ev [int];
    logic [31:0] gold [int];
    logic [31:0] mem_store [int];
    wr_t exp_wq [$];

    function automatic logic [31:0] init_val(input int a);
        return 32'hA500_0000 ^ (32'(a) * 32'h0000_9E37);
    endfunction

    function automatic logic [31:0] gold_val(input int a);
        return gold.exists(a) ? gold[a] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Memory model with a programmable answer delay; checks each access as it completes.
    initial begin : mem_model
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                cnt = 0;
            end else if (mem_valid && !rst) begin
                cnt++;
                if (cnt >= lat) begin
                    ev_idx++;
                    if (mem_rw) begin
                        if (exp_wq.size() == 0) begin
                            chk(0, "R7", "unexpected memory write", int'(mem_addr), -1);
                        end else begin
                            chk(exp_wq[0].a == int'(mem_addr), "R7", "drain address",
                                int'(mem_addr), exp_wq[0].a);
                            chk(exp_wq[0].d == mem_wdata, "R7", "drain data",
                                mem_wdata, exp_wq[0].d);
                            void'(exp_wq.pop_front());
                        end
                        mem_store[int'(mem_addr)] = mem_wdata;
                        last_wr_ev[int'(mem_addr)] = ev_idx;
                        mem_wr_cnt++;
                    end else begin
                        // R9: no acknowledged write to this block may still be pending
                        foreach (exp_wq[i])
                            chk(exp_wq[i].a != int'(mem_addr), "R9", "read overtook write",
                                int'(mem_addr), -1);
                        mem_rdata = mem_store.exists(int'(mem_addr)) ?
                                    mem_store[int'(mem_addr)] : init_val(int'(mem_addr));
                        last_rd_ev[int'(mem_addr)] = ev_idx;
                        mem_rd_cnt++;
                    end
                    mem_ready = 1'b1;
                end
            end
        end
    end

    task automatic xfer(input logic rw, input int a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc);
        @(negedge clk);
        up_valid = 1'b1; up_rw = rw; up_addr = 16'(a); up_wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!up_ready && cyc < 5000);
        rd = up_rdata;
        up_valid = 1'b0;
        if (rw) begin
            gold[a] = d;
            exp_wq.push_back('{a: a, d: d});
            n_wr++;
        end else begin
            chk(rd == gold_val(a), "R2", "read data vs model", rd, gold_val(a));
        end
        @(negedge clk);
        chk(!up_ready, "R12", "ready is one cycle", up_ready, 0);
    endtask

    task automatic settle();
        int guard;
        guard = 0;
        while ((exp_wq.size() != 0 || mem_valid) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin : main
        logic [31:0] rd;
        int cyc, rc, wc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!up_ready, "R1", "up_ready after reset", up_ready, 0);
        chk(!mem_valid, "R1", "mem_valid after reset", mem_valid, 0);

        // R3: cold read miss
        rc = mem_rd_cnt;
        xfer(0, 'h10, '0, rd, cyc);
        chk(cyc == lat + 2, "R3", "miss latency", cyc, lat + 2);
        chk(mem_rd_cnt == rc + 1, "R3", "one memory read", mem_rd_cnt, rc + 1);
        chk(rd == init_val('h10), "R3", "fill data", rd, init_val('h10));

        // R2: read hit
        rc = mem_rd_cnt;
        xfer(0, 'h10, '0, rd, cyc);
        chk(cyc == 1, "R2", "hit latency", cyc, 1);
        chk(mem_rd_cnt == rc, "R2", "no memory read on hit", mem_rd_cnt, rc);

        // R4 / R5: write hit then read hit with new data
        xfer(1, 'h10, 32'h1111_2222, rd, cyc);
        chk(cyc == 1, "R5", "write ack latency", cyc, 1);
        rc = mem_rd_cnt;
        xfer(0, 'h10, '0, rd, cyc);
        chk(cyc == 1 && mem_rd_cnt == rc, "R4", "read after write hit is a hit", cyc, 1);
        chk(rd == 32'h1111_2222, "R4", "updated line data", rd, 32'h1111_2222);
        settle();

        // R6: write miss does not allocate
        xfer(1, 'h22, 32'hCAFE_0022, rd, cyc);
        settle();
        rc = mem_rd_cnt;
        xfer(0, 'h22, '0, rd, cyc);
        chk(mem_rd_cnt == rc + 1, "R6", "read after write miss fetches", mem_rd_cnt, rc + 1);
        chk(cyc == lat + 2, "R6", "miss timing", cyc, lat + 2);

        // R9: read right behind a queued write to the same block
        xfer(1, 'h26, 32'hBEEF_0026, rd, cyc);
        xfer(0, 'h26, '0, rd, cyc);
        chk(cyc > lat + 2, "R9", "read held behind write", cyc, lat + 3);
        chk(last_rd_ev['h26] > last_wr_ev['h26], "R9", "memory order write then read",
            last_rd_ev['h26], last_wr_ev['h26] + 1);
        chk(rd == 32'hBEEF_0026, "R9", "read sees written data", rd, 32'hBEEF_0026);
        settle();

        // R5 / R8: slow memory, fill the queue
        lat = 30;
        for (int k = 0; k < 4; k++) begin
            xfer(1, 'h40 + 4 * k, 32'h4000_0000 + 32'(k), rd, cyc);
            chk(cyc == 1, "R5", "ack without waiting for memory", cyc, 1);
        end
        xfer(1, 'h50, 32'h5000_0050, rd, cyc);
        chk(cyc > 1, "R8", "full queue stalls ack", cyc, 2);
        settle();
        lat = 3;

        // R10 / R11: fill all ways of set 1, then evict
        wc = mem_wr_cnt;
        for (int k = 0; k < 8; k++) begin
            rc = mem_rd_cnt;
            xfer(0, 'h201 + 4 * k, '0, rd, cyc);
            chk(mem_rd_cnt == rc + 1, "R10", "cold fill misses", mem_rd_cnt, rc + 1);
        end
        rc = mem_rd_cnt;
        xfer(0, 'h201 + 32, '0, rd, cyc);
        chk(mem_rd_cnt == rc + 1, "R10", "ninth block misses", mem_rd_cnt, rc + 1);
        rc = mem_rd_cnt;
        for (int k = 1; k < 8; k++) xfer(0, 'h201 + 4 * k, '0, rd, cyc);
        chk(mem_rd_cnt == rc, "R10", "survivors still hit", mem_rd_cnt, rc);
        xfer(0, 'h201, '0, rd, cyc);
        chk(mem_rd_cnt == rc + 1, "R10", "first-filled block was evicted", mem_rd_cnt, rc + 1);
        chk(mem_wr_cnt == wc, "R11", "no writeback on eviction", mem_wr_cnt, wc);

        // R7: all writes delivered
        settle();
        chk(mem_wr_cnt == n_wr, "R7", "write count at memory", mem_wr_cnt, n_wr);
        foreach (gold[a])
            chk(mem_store.exists(a) && mem_store[a] == gold[a], "R7", "memory content",
                mem_store.exists(a) ? mem_store[a] : 0, gold[a]);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule